// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch is taken. It combines two component predictors. The first is a two-level per-branch predictor: a table of local outcome histories, selected by bits of the branch address, picks a 3-bit saturating counter. The second uses a shared record of the most recent branch outcomes to select a 2-bit saturating counter. A third table of 2-bit counters, indexed by that same shared history, decides which component's answer is used for each lookup.

The fetch side presents a branch address on the lookup port. It gets back the predicted direction, and a flag naming the component that supplied it, in the same cycle. When the branch resolves, the back end presents its address and real direction on the update port. The block then retrains both component counters and the chooser, and shifts the outcome into the branch's local history and into the shared history.

With the default sizes the storage is a 1K x 10-bit local history table, a 1K x 3-bit local counter table, a 4K x 2-bit global counter table and a 4K x 2-bit chooser table. That comes to about 29K bits.

Top module: `tourn_predictor`

## Requirements
- R1: After reset every local history and the global history are zero. Every 3-bit counter holds 3, and every global and chooser counter holds 1. Every lookup therefore returns pred_taken=0 and pred_src=0 (local).
- R2: The local prediction is the most significant bit of the 3-bit counter selected by the local history. A counter value of 4 or more means taken. The history entry is selected by address bits lk_pc[PC_LSB +: LHT_W], and the address bits outside that field have no effect.
- R3: On update, every counter moves one step toward the outcome: up when taken, down when not taken. A 3-bit counter saturates at 0 and 7, and a 2-bit counter saturates at 0 and 3.
- R4: The global prediction is the most significant bit of the 2-bit counter indexed by the global history, where bit 0 is the most recent outcome.
- R5: The chooser counter is indexed by the global history. When its most significant bit is 1, the global prediction is used and pred_src=1; otherwise the local prediction is used and pred_src=0.
- R6: On update, the chooser counter steps up when the global prediction was correct and the local one was wrong. It steps down in the opposite case, and it is left unchanged when both were correct or both were wrong. Correctness is judged on the predictions made from the state held before the update.
- R7: On update, the outcome (1 = taken) is shifted into bit 0 of the local history entry of upd_pc and into bit 0 of the global history, and the oldest bit is dropped.
- R8: The lookup is combinational. A lookup in the same cycle as an update sees the state from before that update, and the update is visible from the next cycle on.
- R9: While upd_valid is low, no table or history changes, whatever upd_pc and upd_taken carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_pc | input | PC_W | Address of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_src | output | 1 | Component used: 0 = local, 1 = global |
| upd_valid | input | 1 | Resolved-branch update strobe |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual direction of the resolved branch |

## Verification
The bench runs a small configuration and keeps an arithmetic model of every counter and history. After each update it sweeps every local history entry, with the address bits outside the index field varied. Always-taken, alternating and loop-shaped outcome streams drive the counters into saturation at both ends. A design that wraps instead of saturating would flip the prediction right after a run of identical outcomes, and a design that trains the chooser when both components agree in correctness would switch the prediction source early. A lookup made during the update cycle, and idle cycles with noise on the update inputs, expose a design that writes through to the lookup or updates without the strobe.

// File: rtl/tp_pkg.sv
// Shared types for the tournament predictor.
package tp_pkg;
    // Which component supplied the prediction.
    typedef enum logic {
        SRC_LOCAL  = 1'b0,
        SRC_GLOBAL = 1'b1
    } pred_src_e;
endpackage

// File: rtl/tp_sat_table.sv
// Table of saturating counters with one lookup read port and one
// read-modify-write update port. Assumes a single update per cycle.
// Counters reset to the weakly-not-taken value (MSB clear, all lower bits set).
module tp_sat_table #(
    parameter int IDX_W = 12,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    output logic             lk_msb,
    input  logic [IDX_W-1:0] upd_idx,
    output logic             upd_msb,
    input  logic             upd_en,
    input  logic             upd_up
);
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_MIN = '0;
    localparam logic [CNT_W-1:0] WEAK_NT = CNT_MAX >> 1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q [DEPTH];
    logic [CNT_W-1:0] cur_cnt;
    logic [CNT_W-1:0] nxt_cnt;

    assign cur_cnt = cnt_q[upd_idx];
    assign lk_msb  = cnt_q[lk_idx][CNT_W-1];
    assign upd_msb = cur_cnt[CNT_W-1];

    // Next counter value: one step toward the outcome, held at the ends.
    always_comb begin
        nxt_cnt = cur_cnt;
        if (upd_up && (cur_cnt != CNT_MAX)) begin
            nxt_cnt = cur_cnt + CNT_ONE;
        end else if (!upd_up && (cur_cnt != CNT_MIN)) begin
            nxt_cnt = cur_cnt - CNT_ONE;
        end
    end

    // Counter storage: reset fill, then write the trained entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cnt_q[i] <= WEAK_NT;
            end
        end else if (upd_en) begin
            cnt_q[upd_idx] <= nxt_cnt;
        end
    end

    // R3: a trained entry never moves against the outcome.
    assert_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(upd_en))
        |-> ($past(upd_up) ? (cnt_q[$past(upd_idx)] >= $past(cur_cnt))
                           : (cnt_q[$past(upd_idx)] <= $past(cur_cnt))));

    // R3: a trained entry moves by at most one step.
    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(upd_en))
        |-> ((CNT_W'(cnt_q[$past(upd_idx)] - $past(cur_cnt)) == CNT_MIN) ||
             (CNT_W'(cnt_q[$past(upd_idx)] - $past(cur_cnt)) == CNT_ONE) ||
             (CNT_W'(cnt_q[$past(upd_idx)] - $past(cur_cnt)) == CNT_MAX)));
endmodule

// File: rtl/tp_hist_table.sv
// Per-branch outcome history table. Each entry is a shift register with the
// newest outcome in bit 0. Assumes HIST_W >= 2 and one update per cycle.
module tp_hist_table #(
    parameter int IDX_W  = 10,
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic [HIST_W-1:0] lk_hist,
    input  logic [IDX_W-1:0]  upd_idx,
    output logic [HIST_W-1:0] upd_hist,
    input  logic              upd_en,
    input  logic              upd_bit
);
    localparam int DEPTH = 1 << IDX_W;

    logic [HIST_W-1:0] hist_q [DEPTH];

    assign lk_hist  = hist_q[lk_idx];
    assign upd_hist = hist_q[upd_idx];

    // History storage: clear on reset, shift the outcome into the entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                hist_q[i] <= '0;
            end
        end else if (upd_en) begin
            hist_q[upd_idx] <= {upd_hist[HIST_W-2:0], upd_bit};
        end
    end

    // R7: the entry gains the outcome in bit 0 and keeps its older bits.
    assert_local_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(upd_en))
        |-> ((hist_q[$past(upd_idx)][0] == $past(upd_bit)) &&
             (hist_q[$past(upd_idx)][HIST_W-1:1] == $past(upd_hist[HIST_W-2:0]))));
endmodule

// File: rtl/tp_ghist_reg.sv
// Global outcome history: a shift register, newest outcome in bit 0.
// Assumes HIST_W >= 2.
module tp_ghist_reg #(
    parameter int HIST_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic              upd_bit,
    output logic [HIST_W-1:0] hist
);
    logic [HIST_W-1:0] hist_q;

    assign hist = hist_q;

    // History register: clear on reset, shift on each update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (upd_en) begin
            hist_q <= {hist_q[HIST_W-2:0], upd_bit};
        end
    end

    // R7: an update shifts the outcome in at bit 0.
    assert_global_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(upd_en))
        |-> ((hist_q[0] == $past(upd_bit)) &&
             (hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0]))));

    // R9: without an update the history holds.
    assert_global_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(upd_en)) |-> $stable(hist_q));
endmodule

// File: rtl/tourn_predictor.sv
// Tournament branch direction predictor. A two-level local predictor and a
// global-history predictor each give a direction; a chooser table indexed by
// global history picks one. Lookup is combinational on current state; an
// update trains all tables at the clock edge. Assumes one update per cycle
// and that updates arrive in program order.
module tourn_predictor
    import tp_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int PC_LSB  = 2,
    parameter int LHT_W   = 10,
    parameter int LHIST_W = 10,
    parameter int LCNT_W  = 3,
    parameter int GHIST_W = 12,
    parameter int GCNT_W  = 2,
    parameter int CCNT_W  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            pred_taken,
    output logic            pred_src,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);
    logic [LHT_W-1:0]   lk_lidx;
    logic [LHT_W-1:0]   up_lidx;
    logic [LHIST_W-1:0] lk_lhist;
    logic [LHIST_W-1:0] up_lhist;
    logic [GHIST_W-1:0] ghist;
    logic               lk_local;
    logic               up_local;
    logic               lk_global;
    logic               up_global;
    logic               lk_choose;
    logic               up_choose;
    logic               local_ok;
    logic               global_ok;
    logic               chs_en;
    pred_src_e          src_sel;

    assign lk_lidx = lk_pc[PC_LSB +: LHT_W];
    assign up_lidx = upd_pc[PC_LSB +: LHT_W];

    // Local level one: per-branch histories.
    tp_hist_table #(.IDX_W(LHT_W), .HIST_W(LHIST_W)) u_lht (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(lk_lidx), .lk_hist(lk_lhist),
        .upd_idx(up_lidx), .upd_hist(up_lhist),
        .upd_en(upd_valid), .upd_bit(upd_taken)
    );

    // Local level two: counters selected by the local history.
    tp_sat_table #(.IDX_W(LHIST_W), .CNT_W(LCNT_W)) u_lct (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(lk_lhist), .lk_msb(lk_local),
        .upd_idx(up_lhist), .upd_msb(up_local),
        .upd_en(upd_valid), .upd_up(upd_taken)
    );

    // Shared record of recent outcomes.
    tp_ghist_reg #(.HIST_W(GHIST_W)) u_gh (
        .clk(clk), .rst_n(rst_n),
        .upd_en(upd_valid), .upd_bit(upd_taken), .hist(ghist)
    );

    // Global component counters.
    tp_sat_table #(.IDX_W(GHIST_W), .CNT_W(GCNT_W)) u_gct (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(ghist), .lk_msb(lk_global),
        .upd_idx(ghist), .upd_msb(up_global),
        .upd_en(upd_valid), .upd_up(upd_taken)
    );

    // Chooser training: only when exactly one component was right.
    always_comb begin
        local_ok  = (up_local == upd_taken);
        global_ok = (up_global == upd_taken);
        chs_en    = upd_valid && (local_ok != global_ok);
    end

    // Chooser counters: step up toward global, down toward local.
    tp_sat_table #(.IDX_W(GHIST_W), .CNT_W(CCNT_W)) u_cht (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(ghist), .lk_msb(lk_choose),
        .upd_idx(ghist), .upd_msb(up_choose),
        .upd_en(chs_en), .upd_up(global_ok)
    );

    // Output selection from the chooser's MSB.
    always_comb begin
        src_sel    = lk_choose ? SRC_GLOBAL : SRC_LOCAL;
        pred_src   = src_sel;
        pred_taken = (src_sel == SRC_GLOBAL) ? lk_global : lk_local;
    end

    // R8: a lookup of the branch being updated sees the pre-update state,
    // matching the update-side reads of the same tables.
    assert_same_pc_view_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && (up_lidx == lk_lidx))
        |-> (pred_taken == (up_choose ? up_global : up_local)));

    // R9: with no update and a steady address the prediction holds.
    assert_lookup_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(upd_valid) && $stable(lk_pc))
        |-> ($stable(pred_taken) && $stable(pred_src)));
endmodule

// File: tb/tourn_predictor_tb.sv
`timescale 1ns/1ps
// Bench: small configuration, full sweep of local entries against a model.
module tourn_predictor_tb_top;
    localparam int PC_W = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic            pred_taken;
    logic            pred_src;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Model state: 4 local histories of 3 bits, 8-entry tables.
    int m_lh [4];
    int m_lc [8];
    int m_gc [8];
    int m_ch [8];
    int m_gh;
    int hi_salt = 0;

    always #2.5 clk = ~clk;

    tourn_predictor #(
        .PC_W(PC_W), .PC_LSB(2), .LHT_W(2), .LHIST_W(3), .LCNT_W(3),
        .GHIST_W(3), .GCNT_W(2), .CCNT_W(2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc),
        .pred_taken(pred_taken), .pred_src(pred_src),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
    );

    function automatic logic [PC_W-1:0] mk_pc(int idx, int salt);
        return {salt[3:0], idx[1:0], salt[5:4]};
    endfunction

    function automatic void m_expect(int idx, output bit t, output bit s);
        bit lp;
        bit gp;
        lp = (m_lc[m_lh[idx]] >= 4);
        gp = (m_gc[m_gh] >= 2);
        s  = (m_ch[m_gh] >= 2);
        t  = s ? gp : lp;
    endfunction

    function automatic int sat(int v, bit up, int mx);
        if (up) return (v < mx) ? v + 1 : mx;
        return (v > 0) ? v - 1 : 0;
    endfunction

    task automatic cmp(string tag, int idx);
        bit et;
        bit es;
        m_expect(idx, et, es);
        checks++;
        if (pred_taken !== et) begin
            failures++;
            $display("FAIL %s idx=%0d pred_taken actual=%0b expected=%0b", tag, idx, pred_taken, et);
        end
        checks++;
        if (pred_src !== es) begin
            failures++;
            $display("FAIL %s idx=%0d pred_src actual=%0b expected=%0b", tag, idx, pred_src, es);
        end
    endtask

    // Sweep every local entry, varying the ignored address bits (R2).
    task automatic sweep(string tag);
        for (int i = 0; i < 4; i++) begin
            hi_salt = (hi_salt * 13 + 7) & 63;
            lk_pc = mk_pc(i, hi_salt);
            #0.5;
            cmp(tag, i);
        end
    endtask

    // One update; a same-cycle lookup must see the old state (R8).
    task automatic do_upd(int idx, bit t, string tag);
        int lh;
        bit lp;
        bit gp;
        @(negedge clk);
        hi_salt = (hi_salt * 5 + 3) & 63;
        upd_pc = mk_pc(idx, hi_salt);
        upd_taken = t;
        upd_valid = 1'b1;
        lk_pc = mk_pc(idx, hi_salt ^ 21);
        #0.5;
        cmp("R8 same-cycle lookup", idx);
        @(posedge clk);
        #0.5;
        upd_valid = 1'b0;
        lh = m_lh[idx];
        lp = (m_lc[lh] >= 4);
        gp = (m_gc[m_gh] >= 2);
        m_lc[lh] = sat(m_lc[lh], t, 7);
        m_gc[m_gh] = sat(m_gc[m_gh], t, 3);
        if ((gp == t) && (lp != t)) m_ch[m_gh] = sat(m_ch[m_gh], 1'b1, 3);
        else if ((lp == t) && (gp != t)) m_ch[m_gh] = sat(m_ch[m_gh], 1'b0, 3);
        m_lh[idx] = ((lh << 1) | int'(t)) & 7;
        m_gh = ((m_gh << 1) | int'(t)) & 7;
        sweep(tag);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 5);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr;
        for (int i = 0; i < 4; i++) m_lh[i] = 0;
        for (int i = 0; i < 8; i++) begin
            m_lc[i] = 3;
            m_gc[i] = 1;
            m_ch[i] = 1;
        end
        m_gh = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, everything predicts not-taken from the local side.
        sweep("R1 reset");

        // R3 and R2: drive a 3-bit counter to saturation at the top.
        for (int k = 0; k < 9; k++) do_upd(0, 1'b1, "R3 taken run");
        // R4 and R5: alternating outcomes train global against local.
        for (int k = 0; k < 12; k++) do_upd(1, bit'(k[0]), "R4 alternating");
        // R6: loop-shaped pattern, chooser moves only on disagreement.
        for (int k = 0; k < 16; k++) do_upd(2, (k % 4) != 3, "R6 loop pattern");
        // R3: saturation at the bottom.
        for (int k = 0; k < 10; k++) do_upd(3, 1'b0, "R3 not-taken run");
        // R7 and R5: mixed stream over all entries.
        lfsr = 8'hA5;
        for (int k = 0; k < 200; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            do_upd(int'(lfsr[1:0]), lfsr[6], "R7 mixed stream");
        end

        // R9: noise on the update inputs with the strobe low.
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            upd_pc = 8'(k * 37);
            upd_taken = bit'(k[0]);
        end
        @(negedge clk);
        sweep("R9 idle noise");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule